// File: doc/BRIEF.md
# PRBS and User-Pattern Serial Sequencer

This block drives one serial data channel for a pattern-generator datapath. Each bit comes either from a maximal-length pseudo-random shift register, whose order is picked at run time, or from a small on-chip byte store holding a user pattern. A double-rate enable splits every bit into two halves. This timing lets the output stage apply one of three line codes: non-return-to-zero, return-to-zero, or return-to-one.

A trigger controller can ask for one complete pattern with a start pulse, or it can hold the continuous input high to get repetitions back to back. A marker output is high for the whole first bit of every repetition, so a scope or a downstream checker can lock onto the pattern start. Mode, order, line code and pattern length are plain configuration inputs, held by a register bank outside the block. The byte store is loaded through a simple write port.

Top module: `prbs_pattern_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` and `marker` go to 0 and the block becomes idle.
- R2: When `cfg_src`=0, the bits come from an order-n shift register. n is taken from `cfg_order` for the values 5–15, 23 and 31; any other value acts as 7. The feedback is the XOR of the state bits at tap exponents {5,3}, {6,5}, {7,6}, {8,6,5,4}, {9,5}, {10,7}, {11,9}, {12,11,10,4}, {13,12,11,8}, {14,13,12,2}, {15,14}, {23,18} or {31,28}, where exponent e is state bit e−1. The state shifts toward the MSB with the feedback entering bit 0. The output is the MSB, bit n−1. The seed is all ones, so the period is 2^n−1 bits.
- R3: When `cfg_src`=1, byte k of the store (written by `wr_en`/`wr_addr`/`wr_data`) supplies bits 8k to 8k+7, LSB first. The pattern holds `cfg_len` bytes; a value of 0 counts as 1 and a value above the store depth counts as the depth.
- R4: `cfg_fmt` 0 (and 3) is NRZ: both halves carry the bit. 1 is RZ: the first half carries the bit, the second half is 0. 2 is R1: the first half carries the bit, the second half is 1.
- R5: Each bit lasts two `tick_2x` pulses, first half then second half. `dout` and `marker` change only on clocks with `tick_2x` high. The first half of bit 0 is output on the first tick after the pattern launches.
- R6: `marker` is 1 during both halves of bit 0 of every repetition and 0 at all other times.
- R7: With `cont`=0, a `start` pulse while idle produces exactly one complete pattern, after which the block returns to idle. A `start` while a pattern runs is ignored.
- R8: While `cont`=1, repetitions follow back to back with no gap. After `cont` falls, the repetition in progress completes before the block goes idle.
- R9: A change of `cfg_src` or of the effective order while running restarts the pattern at bit 0 with the all-ones seed and first half.
- R10: While idle, each tick drives `dout` to the rest level: 1 for R1 and 0 otherwise.
- R11: The pattern length is captured when a repetition begins; a change of `cfg_len` takes effect at the next repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_2x | input | 1 | Half-bit enable (two per bit) |
| start | input | 1 | Single-pattern request |
| cont | input | 1 | Continuous repetition enable |
| cfg_src | input | 1 | 0 pseudo-random, 1 user store |
| cfg_order | input | 5 | Shift-register order n |
| cfg_fmt | input | 2 | Line code select |
| cfg_len | input | $clog2(MEM_BYTES)+1 | User pattern length in bytes |
| wr_en | input | 1 | Byte store write strobe |
| wr_addr | input | $clog2(MEM_BYTES) | Byte store write address |
| wr_data | input | 8 | Byte store write data |
| dout | output | 1 | Formatted serial data |
| marker | output | 1 | Pattern-start marker |

## Verification
The bench builds the block with a four-byte store. With that depth, an oversize length request is clamped and a full-depth playback finishes in a few hundred cycles, and the zero-length case is reached as well. Orders 5 and 7 run through complete periods, so the marker spacing and the wrap back to the seed are checked end to end. Orders 23 and 31 and the fallback for an illegal order code are compared over a partial window. Tick spacings of one, two and three clocks show that the half-bit timing follows the enable and not the clock.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, line-code codes and the per-order feedback table.
// Assumes orders never exceed 31.
package pseq_pkg;

    localparam int SR_W  = 31;   // widest shift register
    localparam int IDX_W = 31;   // bit index width, covers 2^31-2

    localparam logic [1:0] FMT_NRZ = 2'd0;
    localparam logic [1:0] FMT_RZ  = 2'd1;
    localparam logic [1:0] FMT_R1  = 2'd2;

    // Map a requested order onto a supported one (unsupported -> 7).
    function automatic logic [4:0] legal_order(input logic [4:0] n);
        case (n)
            5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12,
            5'd13, 5'd14, 5'd15, 5'd23, 5'd31: legal_order = n;
            default:                           legal_order = 5'd7;
        endcase
    endfunction

    // Feedback tap mask: exponent e selects state bit e-1.
    function automatic logic [SR_W-1:0] tap_mask(input logic [4:0] n);
        case (n)
            5'd5:    tap_mask = 31'h0000_0014;
            5'd6:    tap_mask = 31'h0000_0030;
            5'd8:    tap_mask = 31'h0000_00B8;
            5'd9:    tap_mask = 31'h0000_0110;
            5'd10:   tap_mask = 31'h0000_0240;
            5'd11:   tap_mask = 31'h0000_0500;
            5'd12:   tap_mask = 31'h0000_0E08;
            5'd13:   tap_mask = 31'h0000_1C80;
            5'd14:   tap_mask = 31'h0000_3802;
            5'd15:   tap_mask = 31'h0000_6000;
            5'd23:   tap_mask = 31'h0042_0000;
            5'd31:   tap_mask = 31'h4800_0000;
            default: tap_mask = 31'h0000_0060;
        endcase
    endfunction

    // Ones in the low n bits.
    function automatic logic [SR_W-1:0] width_mask(input logic [4:0] n);
        logic [31:0] w;
        w = (32'd1 << n) - 32'd1;
        width_mask = w[SR_W-1:0];
    endfunction

    // Line level for a bit in a given half.
    function automatic logic line_level(input logic [1:0] fmt, input logic b,
                                        input logic second_half);
        case (fmt)
            FMT_RZ:  line_level = second_half ? 1'b0 : b;
            FMT_R1:  line_level = second_half ? 1'b1 : b;
            default: line_level = b;
        endcase
    endfunction

endpackage

// File: rtl/pseq_lfsr.sv
`timescale 1ns/1ps
// Module: pseq_lfsr
// One shift register shared by all orders. Load fills the low bits with
// ones for the new order; step shifts toward the MSB with the XOR of the
// selected taps entering bit 0. Assumes load_order and run_order are legal.
module pseq_lfsr
    import pseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       step,
    input  logic [4:0] load_order,
    input  logic [4:0] run_order,
    output logic       bit_o
);
    logic [SR_W-1:0] state;
    logic [SR_W-1:0] run_mask;
    logic            fb;

    // Purpose: feedback and the active-width mask for the running order.
    always_comb begin
        run_mask = width_mask(run_order);
        fb       = ^(state & tap_mask(run_order));
    end

    // Purpose: seed on load, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '1;
        end else if (load) begin
            state <= width_mask(load_order);
        end else if (step) begin
            state <= {state[SR_W-2:0], fb} & run_mask;
        end
    end

    assign bit_o = state[run_order - 5'd1];

    // R2: the active bits never reach the all-zero lock-up state.
    p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state & run_mask) != '0);

endmodule

// File: rtl/pseq_user_mem.sv
`timescale 1ns/1ps
// Module: pseq_user_mem
// Byte-wide store for the user pattern, written one byte per clock and
// read one bit at a time, LSB first inside each byte. Assumes DEPTH >= 2.
module pseq_user_mem #(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W+2:0] rd_bit,
    output logic              bit_o
);
    logic [7:0] mem [DEPTH];

    // Purpose: byte write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign bit_o = mem[rd_bit[ADDR_W+2:3]][rd_bit[2:0]];

endmodule

// File: rtl/pseq_ctrl.sv
`timescale 1ns/1ps
// Module: pseq_ctrl
// Run/idle control, half-bit phase and bit index. Captures source, order
// and length when a repetition begins, restarts on a source or order
// change, and decides the end of a repetition. Assumes the length in
// bytes never exceeds DEPTH.
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LEN_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             cont,
    input  logic             cfg_src,
    input  logic [4:0]       cfg_order,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             running,
    output logic             phase,
    output logic             at_first,
    output logic [IDX_W-1:0] idx,
    output logic             src_q,
    output logic [4:0]       order_q,
    output logic [4:0]       order_l,
    output logic             seed_load,
    output logic             sr_step
);
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] len_new;
    logic [LEN_W-1:0] eff_bytes;
    logic             restart;
    logic             launch;
    logic             half_adv;
    logic             at_end;

    // Purpose: effective order, effective byte count and the length to capture.
    always_comb begin
        order_l = legal_order(cfg_order);
        if (cfg_len == '0) begin
            eff_bytes = LEN_W'(1);
        end else if (cfg_len > LEN_W'(DEPTH)) begin
            eff_bytes = LEN_W'(DEPTH);
        end else begin
            eff_bytes = cfg_len;
        end
        if (cfg_src) begin
            len_new = IDX_W'({eff_bytes, 3'b000});
        end else begin
            len_new = width_mask(order_l);
        end
    end

    // Purpose: event decode for launch, restart and bit advance.
    always_comb begin
        restart   = running && ((cfg_src != src_q) || (order_l != order_q));
        launch    = !running && (start || cont);
        half_adv  = running && tick && !restart;
        at_end    = (idx == len_q - IDX_W'(1));
        seed_load = restart || launch || (half_adv && phase && at_end);
        sr_step   = half_adv && phase && !at_end;
        at_first  = (idx == '0);
    end

    // Purpose: run flag, phase, index and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            phase   <= 1'b0;
            idx     <= '0;
            len_q   <= IDX_W'(1);
            src_q   <= 1'b0;
            order_q <= 5'd7;
        end else if (restart || launch) begin
            running <= 1'b1;
            phase   <= 1'b0;
            idx     <= '0;
            len_q   <= len_new;
            src_q   <= cfg_src;
            order_q <= order_l;
        end else if (half_adv) begin
            if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (at_end) begin
                    idx   <= '0;
                    len_q <= len_new;
                    if (!cont) begin
                        running <= 1'b0;
                    end
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // R11: the index stays inside the captured length while running.
    p_idx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (idx < len_q));

    // R7: the last half of a single-shot repetition ends the run.
    p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_adv && phase && at_end && !cont) |=> !running);

endmodule

// File: rtl/pseq_fmt.sv
`timescale 1ns/1ps
// Module: pseq_fmt
// Output stage: on each tick registers the line level for the current bit
// and half, plus the marker, or the rest level when idle.
module pseq_fmt
    import pseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       running,
    input  logic       phase,
    input  logic       at_first,
    input  logic       bit_i,
    input  logic [1:0] fmt,
    output logic       dout,
    output logic       marker
);
    // Purpose: tick-aligned output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= 1'b0;
            marker <= 1'b0;
        end else if (tick) begin
            if (running) begin
                dout   <= line_level(fmt, bit_i, phase);
                marker <= at_first;
            end else begin
                dout   <= (fmt == FMT_R1);
                marker <= 1'b0;
            end
        end
    end

    // R5: outputs hold between ticks.
    p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(dout) && $stable(marker)));

    // R6: no marker from an idle tick.
    p_idle_no_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && tick) |=> !marker);

    // R10: idle ticks drive the rest level of the selected line code.
    p_idle_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && tick) |=> (dout == $past(fmt == FMT_R1)));

endmodule

// File: rtl/prbs_pattern_seq.sv
`timescale 1ns/1ps
// Module: prbs_pattern_seq (top)
// Serial pattern sequencer: pseudo-random or stored user bits, formatted
// as NRZ/RZ/R1 on a double-rate enable, with a pattern-start marker.
// Assumes MEM_BYTES >= 2 and that the store is not written while a user
// pattern plays.
module prbs_pattern_seq
    import pseq_pkg::*;
#(
    parameter int MEM_BYTES = 32,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_2x,
    input  logic              start,
    input  logic              cont,
    input  logic              cfg_src,
    input  logic [4:0]        cfg_order,
    input  logic [1:0]        cfg_fmt,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              dout,
    output logic              marker
);
    logic             running;
    logic             phase;
    logic             at_first;
    logic [IDX_W-1:0] idx;
    logic             src_q;
    logic [4:0]       order_q;
    logic [4:0]       order_l;
    logic             seed_load;
    logic             sr_step;
    logic             sr_bit;
    logic             mem_bit;
    logic             cur_bit;

    pseq_ctrl #(.DEPTH(MEM_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_2x),
        .start     (start),
        .cont      (cont),
        .cfg_src   (cfg_src),
        .cfg_order (cfg_order),
        .cfg_len   (cfg_len),
        .running   (running),
        .phase     (phase),
        .at_first  (at_first),
        .idx       (idx),
        .src_q     (src_q),
        .order_q   (order_q),
        .order_l   (order_l),
        .seed_load (seed_load),
        .sr_step   (sr_step)
    );

    pseq_lfsr u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seed_load),
        .step       (sr_step),
        .load_order (order_l),
        .run_order  (order_q),
        .bit_o      (sr_bit)
    );

    pseq_user_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bit  (idx[ADDR_W+2:0]),
        .bit_o   (mem_bit)
    );

    assign cur_bit = src_q ? mem_bit : sr_bit;

    pseq_fmt u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_2x),
        .running  (running),
        .phase    (phase),
        .at_first (at_first),
        .bit_i    (cur_bit),
        .fmt      (cfg_fmt),
        .dout     (dout),
        .marker   (marker)
    );

endmodule

// File: tb/prbs_pattern_seq_test.sv
`timescale 1ns/1ps
module prbs_pattern_seq_test;
    localparam int MEM_BYTES = 4;
    localparam int ADDR_W = 2;
    localparam int LEN_W = 3;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_2x = 1'b0;
    logic start = 1'b0;
    logic cont = 1'b0;
    logic cfg_src = 1'b0;
    logic [4:0] cfg_order = 5'd5;
    logic [1:0] cfg_fmt = 2'd0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic dout, marker;

    always #2.5 clk = ~clk;

    prbs_pattern_seq #(.MEM_BYTES(MEM_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .start(start), .cont(cont),
        .cfg_src(cfg_src), .cfg_order(cfg_order), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .marker(marker));

    int n_checks = 0, n_fail = 0, cyc = 0, tick_div = 1;
    int last_rise = -1, last_gap = 0, rises = 0;
    logic prev_marker = 1'b0;
    bit model_valid = 0;
    string cur_req = "R1";

    // ---------------- reference model ----------------
    bit m_run, m_ph, m_src, m_dout, m_mark;
    int m_ord;
    longint m_idx, m_len, m_lfsr;
    logic [7:0] shadow [MEM_BYTES];

    function automatic int eff_order(input int o);
        if ((o >= 5 && o <= 15) || o == 23 || o == 31) return o;
        return 7;
    endfunction

    function automatic longint tb(input int e);
        return longint'(1) << (e - 1);
    endfunction

    function automatic longint taps(input int n);
        case (n)
            5:  return tb(5) | tb(3);
            6:  return tb(6) | tb(5);
            8:  return tb(8) | tb(6) | tb(5) | tb(4);
            9:  return tb(9) | tb(5);
            10: return tb(10) | tb(7);
            11: return tb(11) | tb(9);
            12: return tb(12) | tb(11) | tb(10) | tb(4);
            13: return tb(13) | tb(12) | tb(11) | tb(8);
            14: return tb(14) | tb(13) | tb(12) | tb(2);
            15: return tb(15) | tb(14);
            23: return tb(23) | tb(18);
            31: return tb(31) | tb(28);
            default: return tb(7) | tb(6);
        endcase
    endfunction

    function automatic longint calc_len(input bit src, input int ord, input int lenf);
        int b;
        if (!src) return (longint'(1) << ord) - 1;
        b = (lenf == 0) ? 1 : ((lenf > MEM_BYTES) ? MEM_BYTES : lenf);
        return longint'(b) * 8;
    endfunction

    function automatic bit level(input int fmt, input bit b, input bit half);
        if (fmt == 1) return half ? 1'b0 : b;
        if (fmt == 2) return half ? 1'b1 : b;
        return b;
    endfunction

    task automatic m_begin();
        m_run = 1; m_ph = 0; m_idx = 0; m_src = cfg_src;
        m_ord = eff_order(int'(cfg_order));
        m_len = calc_len(m_src, m_ord, int'(cfg_len));
        m_lfsr = (longint'(1) << m_ord) - 1;
    endtask

    always @(posedge clk) begin
        bit b;
        if (!rst_n) begin
            m_run = 0; m_ph = 0; m_idx = 0; m_dout = 0; m_mark = 0;
            m_src = 0; m_ord = 7; m_len = 1; m_lfsr = 1;
        end else begin
            if (tick_2x) begin
                if (m_run) begin
                    if (m_src) b = shadow[m_idx / 8][m_idx % 8];
                    else b = m_lfsr[m_ord - 1];
                    m_dout = level(int'(cfg_fmt), b, m_ph);
                    m_mark = (m_idx == 0);
                end else begin
                    m_dout = (cfg_fmt == 2'd2); m_mark = 0;
                end
            end
            if (m_run && (cfg_src != m_src || eff_order(int'(cfg_order)) != m_ord)) m_begin();
            else if (!m_run && (start || cont)) m_begin();
            else if (m_run && tick_2x) begin
                if (!m_ph) m_ph = 1;
                else begin
                    m_ph = 0;
                    if (m_idx == m_len - 1) begin
                        m_idx = 0;
                        m_len = calc_len(m_src, m_ord, int'(cfg_len));
                        m_lfsr = (longint'(1) << m_ord) - 1;
                        if (!cont) m_run = 0;
                    end else begin
                        m_idx++;
                        m_lfsr = ((m_lfsr << 1) | longint'($countones(m_lfsr & taps(m_ord)) & 1))
                                 & ((longint'(1) << m_ord) - 1);
                    end
                end
            end
        end
        if (wr_en) shadow[wr_addr] = wr_data;
        model_valid = 1;
    end

    // ------------- per-cycle compare, tick driver, watchdog -------------
    always @(negedge clk) begin
        cyc++;
        if (model_valid && rst_n) begin
            n_checks++;
            if (dout !== m_dout || marker !== m_mark) begin
                n_fail++;
                $display("FAIL %s cycle %0d dout=%b exp=%b marker=%b exp=%b",
                         cur_req, cyc, dout, m_dout, marker, m_mark);
            end
        end
        if (marker && !prev_marker) begin
            if (last_rise >= 0) last_gap = cyc - last_rise;
            last_rise = cyc;
            rises++;
        end
        prev_marker = marker;
        tick_2x = (tick_div <= 1) || (cyc % tick_div == 0);
        if (cyc > LIMIT) begin
            n_checks++; n_fail++;
            $display("FAIL R7 watchdog expired act=%0d exp<=%0d", cyc, LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; cont = 0; start = 0;
        run(3); rst_n = 1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic clear_marks();
        last_rise = -1; last_gap = 0; rises = 0;
    endtask

    task automatic write_byte(input int a, input int d);
        @(negedge clk); wr_en = 1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3); rst_n = 1; run(1);
        chk(dout == 0, "R1 dout after reset", int'(dout), 0);
        chk(marker == 0, "R1 marker after reset", int'(marker), 0);
        run(5);

        // R2/R6: order 5, NRZ, tick every clock, continuous
        cur_req = "R2"; tick_div = 1; cfg_src = 0; cfg_order = 5'd5; cfg_fmt = 2'd0;
        clear_marks(); cont = 1; run(260);
        chk(last_gap == 62, "R2 period order 5 (ticks)", last_gap, 62);
        chk(rises >= 3, "R6 marker per repetition", rises, 3);

        // R4/R5: order 7, RZ, tick every other clock
        cur_req = "R4"; tick_div = 2; cfg_fmt = 2'd1; cfg_order = 5'd7;
        clear_marks(); run(1100);
        chk(last_gap == 508, "R5 order 7 period with half-rate ticks", last_gap, 508);

        // R9: order and source changes while running
        cur_req = "R9"; tick_div = 3; cfg_fmt = 2'd2; cfg_order = 5'd23; run(400);
        cfg_order = 5'd31; run(300);
        cfg_order = 5'd20; run(400);          // illegal -> order 7
        cfg_order = 5'd14; run(200);
        cfg_fmt = 2'd3; cfg_order = 5'd5; run(200);
        // R8: dropping cont finishes the pattern
        cur_req = "R8"; cont = 0; run(400);
        // R10: idle rest level for R1
        cur_req = "R10"; cfg_fmt = 2'd2; run(10);
        chk(dout == 1, "R10 idle rest level R1", int'(dout), 1);
        cfg_fmt = 2'd1; run(10);
        chk(dout == 0, "R10 idle rest level RZ", int'(dout), 0);

        // R3/R7: user pattern, triggered
        do_reset();
        cur_req = "R3"; tick_div = 2; cfg_fmt = 2'd0;
        write_byte(0, 8'hA5); write_byte(1, 8'h3C); write_byte(2, 8'hF0); write_byte(3, 8'h81);
        cfg_src = 1; cfg_len = 3'd2; clear_marks();
        pulse_start(); run(20);
        cur_req = "R7"; pulse_start(); run(200);
        chk(rises == 1, "R7 one pattern per start", rises, 1);
        chk(dout == 0 && marker == 0, "R7 idle after single pattern", int'(dout), 0);
        cur_req = "R3"; cfg_len = 3'd0; clear_marks(); pulse_start(); run(60);
        chk(rises == 1, "R3 zero length acts as one byte", rises, 1);
        cfg_len = 3'd7; cfg_fmt = 2'd2; pulse_start(); run(300);

        // R11/R8: length change mid-run in continuous
        cur_req = "R11"; cfg_fmt = 2'd0; cfg_len = 3'd2; tick_div = 2; clear_marks();
        cont = 1; run(100);
        chk(last_gap == 64, "R11 two-byte repetition spacing", last_gap, 64);
        cfg_len = 3'd1; run(200);
        chk(last_gap == 32, "R11 new length at next repetition", last_gap, 32);
        cfg_src = 0; run(100);                // R9 source change
        cur_req = "R8"; cont = 0; run(300);
        chk(dout == 0, "R8 idle after cont drop", int'(dout), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule